// File: doc/BRIEF.md
# Parallel Panel Write Sequencer

This block drives an 8080-style parallel write bus into a display panel that keeps its own frame memory. Software sets the per-word bus timing, the frame dimensions and the interface enable through a small register port. It then arms a frame with a trigger, either by writing the trigger register or by pulsing a strobe pin. The sequencer pulls pixels from a valid/ready stream and emits one bus write per pixel. When the last word has been written, it releases chip select and raises a sticky frame-done interrupt.

Each word passes through four programmable phases: a chip-select setup wait, a write-strobe setup wait, a write-strobe low period, and a hold wait. The timing is captured when the frame starts, so software may reprogram the next frame while the current one is still running. A trigger that arrives during a frame is discarded, because a repeated trigger can upset the panel.

Top module: `i80_write_seq`

## Requirements
- R1: After reset, lcd_cs_n and lcd_wr_n are 1, lcd_rs, busy, frame_irq and pix_ready are 0, lcd_db is 0, and the timing register holds chip-select setup 0, strobe setup 0, strobe active 1, hold 0, with the interface disabled.
- R2: Register 0 holds the timing fields: chip-select setup at bits 19:16, strobe setup at bits 15:12, strobe active at bits 11:8 and hold at bits 7:4. Bit 0 is the interface enable, and no frame starts while it is 0. With the reset timing, each strobe low pulse lasts 2 clocks.
- R3: A frame starts only when the start request and the trigger mode are both present, the interface is on and the block is idle. The start request is a register 1 write with bit 1 set, or a trig pulse. The trigger mode is register 1 bit 0: the value being written in that same cycle, otherwise the stored value. The interface is on when register 0 bit 0 is 1 and the enable pin is 1.
- R4: Each word takes, after the pixel is accepted, chip-select setup clocks, then strobe setup clocks, then strobe active+1 clocks with lcd_wr_n low, then hold clocks. A phase with a zero count is skipped.
- R5: pix_ready is 1 only while the block waits for a pixel. The accepted pixel appears on lcd_db on the next clock and stays unchanged until the word's hold phase has ended.
- R6: lcd_cs_n is 0 and lcd_rs is 1 for the whole frame, from the start clock to the end of the last word, and lcd_wr_n is never 0 while lcd_cs_n is 1.
- R7: The frame length is width × height words. Width is register 2 bits 9:0 and height is register 2 bits 25:16. A trigger with a zero product is ignored.
- R8: A trigger, by register write or by pin, that arrives while a frame is running has no effect on that frame and is not queued.
- R9: frame_irq is a sticky bit. It is set in the clock after the last word ends and cleared by writing 1 to register 3 bit 0; setting wins over clearing in the same clock.
- R10: If the interface turns off during a frame, the current word completes, no further word is fetched, the block returns to idle and frame_irq is not set.
- R11: Timing fields written during a frame take effect only from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable, ANDed with register 0 bit 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 timing, 1 trigger, 2 size, 3 status |
| cfg_wdata | input | 32 | Register write data |
| trig | input | 1 | Trigger strobe pin |
| pix_data | input | 16 | Pixel word |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Sequencer accepts a pixel |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_rs | output | 1 | Register/data select, 1 for pixel data |
| lcd_db | output | 16 | Panel data bus |
| busy | output | 1 | Frame in progress |
| frame_irq | output | 1 | Sticky frame-done flag |

## Verification
The bench checks that the strobe-low width follows the timing captured at frame start, even after register 0 is rewritten mid-frame. A design that reads the live fields would narrow the pulses of the remaining words. It also fires triggers by pin and by register while a frame runs: a design that restarts or queues them would write more words than width × height, or raise busy again after the frame. The bench throttles the pixel stream so that a design that moves lcd_db outside a handshake shows up at once in the per-clock comparison. It drops the enable pin mid-frame to catch a design that still raises the interrupt or keeps fetching pixels.

// File: rtl/i80_pkg.sv
package i80_pkg;
  localparam int TW = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_CSS,
    PH_WRS,
    PH_WRA,
    PH_WRH
  } phase_e;

  typedef struct packed {
    logic [TW-1:0] css;
    logic [TW-1:0] wrs;
    logic [TW-1:0] wra;
    logic [TW-1:0] wrh;
  } tcfg_t;

  localparam logic [1:0] REG_TIMING = 2'd0;
  localparam logic [1:0] REG_TRIG   = 2'd1;
  localparam logic [1:0] REG_SIZE   = 2'd2;
  localparam logic [1:0] REG_STAT   = 2'd3;

  localparam tcfg_t TCFG_RST = '{css: 4'd0, wrs: 4'd0, wra: 4'd1, wrh: 4'd0};
endpackage

// File: rtl/i80_cfg_regs.sv
module i80_cfg_regs
  import i80_pkg::*;
#(
  parameter int DIM_W = 10,
  localparam int FW = 2 * DIM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          trig_i,
  input  logic          idle_i,
  input  logic          frame_end_i,
  output tcfg_t         tcfg_o,
  output logic          if_on_o,
  output logic          start_o,
  output logic [FW-1:0] frame_words_o,
  output logic          done_o
);
  tcfg_t            tcfg_q, tcfg_d;
  logic             en_q, en_d;
  logic             mode_q, mode_d;
  logic [DIM_W-1:0] width_q, width_d;
  logic [DIM_W-1:0] height_q, height_d;
  logic             done_q, done_d;

  logic wr_timing, wr_trig, wr_size, wr_stat;
  logic trig_cmd, mode_eff, clr_req;
  logic unused_wdata;

  assign wr_timing = cfg_we && (cfg_addr == REG_TIMING);
  assign wr_trig   = cfg_we && (cfg_addr == REG_TRIG);
  assign wr_size   = cfg_we && (cfg_addr == REG_SIZE);
  assign wr_stat   = cfg_we && (cfg_addr == REG_STAT);

  assign trig_cmd = (wr_trig && cfg_wdata[1]) || trig_i;
  assign mode_eff = wr_trig ? cfg_wdata[0] : mode_q;
  assign clr_req  = wr_stat && cfg_wdata[0];
  assign unused_wdata = ^cfg_wdata;

  assign frame_words_o = FW'(width_q) * FW'(height_q);
  assign if_on_o       = en_q && enable_i;
  assign start_o       = idle_i && trig_cmd && mode_eff && if_on_o &&
                         (frame_words_o != '0);
  assign tcfg_o        = tcfg_q;
  assign done_o        = done_q;

  always_comb begin
    tcfg_d   = tcfg_q;
    en_d     = en_q;
    mode_d   = mode_q;
    width_d  = width_q;
    height_d = height_q;
    done_d   = done_q;
    if (wr_timing) begin
      tcfg_d.css = cfg_wdata[19:16];
      tcfg_d.wrs = cfg_wdata[15:12];
      tcfg_d.wra = cfg_wdata[11:8];
      tcfg_d.wrh = cfg_wdata[7:4];
      en_d       = cfg_wdata[0];
    end
    if (wr_trig) mode_d = cfg_wdata[0];
    if (wr_size) begin
      width_d  = cfg_wdata[DIM_W-1:0];
      height_d = cfg_wdata[16+DIM_W-1:16];
    end
    if (clr_req)     done_d = 1'b0;
    if (frame_end_i) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcfg_q   <= TCFG_RST;
      en_q     <= 1'b0;
      mode_q   <= 1'b0;
      width_q  <= '0;
      height_q <= '0;
      done_q   <= 1'b0;
    end else begin
      tcfg_q   <= tcfg_d;
      en_q     <= en_d;
      mode_q   <= mode_d;
      width_q  <= width_d;
      height_q <= height_d;
      done_q   <= done_d;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_req) |=> done_q); // R9
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> idle_i); // R8
  AST_START_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (width_q != '0 && height_q != '0)); // R7
endmodule

// File: rtl/i80_cycle_fsm.sv
module i80_cycle_fsm
  import i80_pkg::*;
#(
  parameter int DW = 16,
  parameter int DIM_W = 10,
  localparam int FW = 2 * DIM_W,
  localparam int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  tcfg_t         tcfg_i,
  input  logic [FW-1:0] frame_words_i,
  input  logic          if_on_i,
  input  logic [DW-1:0] pix_data_i,
  input  logic          pix_valid_i,
  output logic          pix_ready_o,
  output logic          cs_n_o,
  output logic          wr_n_o,
  output logic          rs_o,
  output logic [DW-1:0] db_o,
  output logic          busy_o,
  output logic          frame_end_o
);
  phase_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [FW-1:0] left_q, left_d;
  tcfg_t         snap_q, snap_d;
  logic [DW-1:0] db_q;
  logic          db_en, word_done, in_phase;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    left_d      = left_q;
    snap_d      = snap_q;
    db_en       = 1'b0;
    word_done   = 1'b0;
    frame_end_o = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          state_d = PH_FETCH;
          left_d  = frame_words_i;
          snap_d  = tcfg_i;
        end
      end
      PH_FETCH: begin
        if (!if_on_i) begin
          state_d = PH_IDLE;
        end else if (pix_valid_i) begin
          db_en = 1'b1;
          if (snap_q.css != '0) begin
            state_d = PH_CSS;
            cnt_d   = {1'b0, snap_q.css} - CW'(1);
          end else if (snap_q.wrs != '0) begin
            state_d = PH_WRS;
            cnt_d   = {1'b0, snap_q.wrs} - CW'(1);
          end else begin
            state_d = PH_WRA;
            cnt_d   = {1'b0, snap_q.wra};
          end
        end
      end
      PH_CSS: begin
        if (cnt_q == '0) begin
          if (snap_q.wrs != '0) begin
            state_d = PH_WRS;
            cnt_d   = {1'b0, snap_q.wrs} - CW'(1);
          end else begin
            state_d = PH_WRA;
            cnt_d   = {1'b0, snap_q.wra};
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_WRS: begin
        if (cnt_q == '0) begin
          state_d = PH_WRA;
          cnt_d   = {1'b0, snap_q.wra};
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_WRA: begin
        if (cnt_q == '0) begin
          if (snap_q.wrh != '0) begin
            state_d = PH_WRH;
            cnt_d   = {1'b0, snap_q.wrh} - CW'(1);
          end else begin
            word_done = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_WRH: begin
        if (cnt_q == '0) word_done = 1'b1;
        else             cnt_d = cnt_q - CW'(1);
      end
      default: state_d = PH_IDLE;
    endcase
    if (word_done) begin
      if (left_q == FW'(1)) begin
        state_d     = PH_IDLE;
        frame_end_o = 1'b1;
      end else begin
        state_d = PH_FETCH;
        left_d  = left_q - FW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      snap_q  <= TCFG_RST;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      snap_q  <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     db_q <= '0;
    else if (db_en) db_q <= pix_data_i;
  end

  assign in_phase    = (state_q == PH_CSS) || (state_q == PH_WRS) ||
                       (state_q == PH_WRA) || (state_q == PH_WRH);
  assign busy_o      = (state_q != PH_IDLE);
  assign cs_n_o      = !busy_o;
  assign rs_o        = busy_o;
  assign wr_n_o      = (state_q != PH_WRA);
  assign pix_ready_o = (state_q == PH_FETCH);
  assign db_o        = db_q;

  AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> !cs_n_o); // R6
  AST_DB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_phase && $past(in_phase)) |-> $stable(db_q)); // R5
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(snap_q)); // R11
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (left_q <= $past(left_q))); // R8
  AST_WRA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WRA) |-> (cnt_q <= {1'b0, snap_q.wra})); // R4
endmodule

// File: rtl/i80_write_seq.sv
module i80_write_seq
  import i80_pkg::*;
#(
  parameter int DW = 16,
  parameter int DIM_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          trig,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_valid,
  output logic          pix_ready,
  output logic          lcd_cs_n,
  output logic          lcd_wr_n,
  output logic          lcd_rs,
  output logic [DW-1:0] lcd_db,
  output logic          busy,
  output logic          frame_irq
);
  localparam int FW = 2 * DIM_W;

  tcfg_t         tcfg;
  logic          if_on, start, frame_end;
  logic [FW-1:0] frame_words;

  i80_cfg_regs #(.DIM_W(DIM_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .trig_i       (trig),
    .idle_i       (!busy),
    .frame_end_i  (frame_end),
    .tcfg_o       (tcfg),
    .if_on_o      (if_on),
    .start_o      (start),
    .frame_words_o(frame_words),
    .done_o       (frame_irq)
  );

  i80_cycle_fsm #(.DW(DW), .DIM_W(DIM_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .tcfg_i       (tcfg),
    .frame_words_i(frame_words),
    .if_on_i      (if_on),
    .pix_data_i   (pix_data),
    .pix_valid_i  (pix_valid),
    .pix_ready_o  (pix_ready),
    .cs_n_o       (lcd_cs_n),
    .wr_n_o       (lcd_wr_n),
    .rs_o         (lcd_rs),
    .db_o         (lcd_db),
    .busy_o       (busy),
    .frame_end_o  (frame_end)
  );
endmodule

// File: tb/i80_write_seq_test.sv
module i80_write_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        trig = 1'b0;
  logic [15:0] pix_data = 16'h1234;
  logic        pix_valid = 1'b0;
  logic        pix_ready, lcd_cs_n, lcd_wr_n, lcd_rs, busy, frame_irq;
  logic [15:0] lcd_db;

  always #10 clk = ~clk;

  i80_write_seq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .trig(trig),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rs(lcd_rs),
    .lcd_db(lcd_db), .busy(busy), .frame_irq(frame_irq)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated on every rising edge.
  int          m_tim = 32'h100;
  bit          m_mode = 0;
  int          m_w = 0, m_h = 0;
  bit          m_busy = 0, m_done = 0, m_take = 0, m_end = 0;
  int          m_left = 0, m_t = -1;
  int          m_cs = 0, m_ws = 0, m_wa = 1, m_wh = 0;
  logic [15:0] m_db = '0;
  bit          cmd, mode_eff, on;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tim = 32'h100; m_mode = 0; m_w = 0; m_h = 0; m_busy = 0; m_done = 0;
      m_left = 0; m_t = -1; m_db = '0; m_take = 0; m_end = 0;
    end else begin
      m_take = 0; m_end = 0;
      cmd      = (cfg_we && cfg_addr == 2'd1 && cfg_wdata[1]) || trig;
      mode_eff = (cfg_we && cfg_addr == 2'd1) ? cfg_wdata[0] : m_mode;
      on       = m_tim[0] && enable;
      if (!m_busy) begin
        if (cmd && mode_eff && on && (m_w * m_h > 0)) begin
          m_busy = 1; m_left = m_w * m_h; m_t = -1;
          m_cs = (m_tim >> 16) & 15; m_ws = (m_tim >> 12) & 15;
          m_wa = (m_tim >> 8) & 15;  m_wh = (m_tim >> 4) & 15;
        end
      end else if (m_t < 0) begin
        if (!on) m_busy = 0;
        else if (pix_valid) begin m_db = pix_data; m_t = 0; m_take = 1; end
      end else begin
        m_t++;
        if (m_t == m_cs + m_ws + m_wa + 1 + m_wh) begin
          m_left--;
          if (m_left == 0) begin m_busy = 0; m_end = 1; end
          else m_t = -1;
        end
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_tim = int'(cfg_wdata & 32'h000F_FFF1);
          2'd1: m_mode = cfg_wdata[0];
          2'd2: begin m_w = int'(cfg_wdata[9:0]); m_h = int'(cfg_wdata[25:16]); end
          default: if (cfg_wdata[0]) m_done = 0;
        endcase
      end
      if (m_end) m_done = 1;
    end
  end

  // Pixel source
  bit gap_mode = 0;
  int gcnt = 0;
  always @(negedge clk) begin
    if (m_take) pix_data <= pix_data + 16'h0101;
    pix_valid <= rst_n && (gap_mode ? (gcnt % 3 != 0) : 1'b1);
    gcnt <= gcnt + 1;
  end

  // Per-clock comparison against the model
  bit exp_wr;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_wr = m_busy && m_t >= m_cs + m_ws && m_t <= m_cs + m_ws + m_wa;
      check("R6 cs_n", lcd_cs_n, !m_busy);
      check("R6 rs", lcd_rs, m_busy);
      check("R4 wr_n", lcd_wr_n, !exp_wr);
      check("R5 db", lcd_db, m_db);
      check("R5 pix_ready", pix_ready, m_busy && m_t < 0);
      check("R3 busy", busy, m_busy);
      check("R9 frame_irq", frame_irq, m_done);
    end
  end

  // Bus monitor
  int run = 0, words = 0, lowmin = 999, lowmax = 0, cs_rise = 0, hs = 0;
  logic prev_cs = 1'b1;
  always @(negedge clk) begin
    if (!lcd_wr_n) run++;
    else if (run > 0) begin
      words++;
      if (run < lowmin) lowmin = run;
      if (run > lowmax) lowmax = run;
      run = 0;
    end
    if (lcd_cs_n && !prev_cs) cs_rise++;
    prev_cs = lcd_cs_n;
    if (pix_valid && pix_ready) hs++;
  end

  task automatic mon_clear();
    words = 0; lowmin = 999; lowmax = 0; cs_rise = 0; hs = 0;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] timing(input int cs, ws, wa, wh, en);
    return (32'(cs) << 16) | (32'(ws) << 12) | (32'(wa) << 8) | (32'(wh) << 4) | 32'(en);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cs_n", lcd_cs_n, 1); check("R1 wr_n", lcd_wr_n, 1);
    check("R1 rs", lcd_rs, 0);     check("R1 busy", busy, 0);
    check("R1 irq", frame_irq, 0); check("R1 db", lcd_db, 0);
    check("R1 ready", pix_ready, 0);

    // Default timing, 3x2 frame, register trigger
    cfg_write(2'd0, 32'h101);
    cfg_write(2'd2, (32'd2 << 16) | 32'd3);
    mon_clear();
    cfg_write(2'd1, 32'h3);
    wait_idle();
    check("R7 words written", words, 6);
    check("R2 default strobe low min", lowmin, 2);
    check("R2 default strobe low max", lowmax, 2);
    check("R6 one cs release", cs_rise, 1);
    check("R5 handshakes", hs, 6);
    check("R9 irq after frame", frame_irq, 1);

    // W1C, custom timing, pin trigger, retrigger while busy, gapped stream
    cfg_write(2'd3, 32'h1);
    check("R9 irq cleared", frame_irq, 0);
    cfg_write(2'd0, timing(2, 1, 3, 2, 1));
    gap_mode = 1;
    mon_clear();
    pulse_trig();
    repeat (5) @(negedge clk);
    pulse_trig();
    cfg_write(2'd1, 32'h3);
    wait_idle();
    gap_mode = 0;
    check("R8 words with retrigger", words, 6);
    check("R4 strobe low min", lowmin, 4);
    check("R4 strobe low max", lowmax, 4);
    check("R8 no queued frame", busy, 0);
    check("R9 irq set", frame_irq, 1);

    // Start conditions
    cfg_write(2'd3, 32'h1);
    cfg_write(2'd1, 32'h2);
    @(negedge clk);
    check("R3 command without mode", busy, 0);
    cfg_write(2'd1, 32'h1);
    @(negedge clk);
    check("R3 mode without command", busy, 0);
    enable = 1'b0;
    pulse_trig();
    check("R3 enable pin low", busy, 0);
    enable = 1'b1;
    cfg_write(2'd0, timing(2, 1, 3, 2, 0));
    pulse_trig();
    check("R2 enable bit clear", busy, 0);

    // Zero-length frame
    cfg_write(2'd0, timing(0, 0, 3, 0, 1));
    cfg_write(2'd2, 32'd5);
    pulse_trig();
    check("R7 zero frame ignored", busy, 0);

    // Timing rewritten mid-frame
    cfg_write(2'd2, (32'd2 << 16) | 32'd2);
    mon_clear();
    pulse_trig();
    repeat (3) @(negedge clk);
    cfg_write(2'd0, timing(0, 0, 0, 0, 1));
    wait_idle();
    check("R11 words", words, 4);
    check("R11 strobe low min", lowmin, 4);
    check("R11 strobe low max", lowmax, 4);

    // Abort by enable pin
    cfg_write(2'd0, timing(1, 1, 3, 1, 1));
    cfg_write(2'd2, (32'd2 << 16) | 32'd3);
    cfg_write(2'd3, 32'h1);
    mon_clear();
    pulse_trig();
    for (int i = 0; i < 200 && words < 1; i++) @(negedge clk);
    enable = 1'b0;
    wait_idle();
    check("R10 stopped early", (words < 6) ? 1 : 0, 1);
    check("R10 no irq", frame_irq, 0);
    check("R10 cs released", lcd_cs_n, 1);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule